// File: doc/BRIEF.md
# Sub-Audible Squelch Tone PWM Generator

This block produces one of eight sub-audible squelch tones as a pulse-width-modulated logic waveform. A low-pass filter placed after the pin recovers the sine. Each tone cycle is built from 32 PWM periods. Each period carries one sample of a sine wave, and that sample is scaled to the period length. The tone pitch is set by the length of the PWM period, which is the terminal count of a prescaled counter. The pitch is not set by stepping a phase accumulator at a fixed rate.

The tone is chosen by a 3-bit select input. The block captures the select once, on the first clock after reset is released, and keeps it until the next reset. An active-low key input gates the tone. While the key is held low, a transmit indicator output is high and the sample index advances at every PWM period. While the key is released, the index and the compare value stand still, so the pin keeps its last duty cycle. Every sample update is marked by a one-clock strobe.

Top module: `tone_pwm_gen`

## Requirements
- R1: While reset is asserted, tx_on_o and sample_stb_o are 0 and pwm_o is 1. The tone select is captured on the first clock after reset release.
- R2: Tone select codes map to period terminal counts (TOP) as follows: 0→289, 1→699, 2→529, 3→552, 4→468, 5→452, 6→608, 7→548.
- R3: The PWM counter counts 0..TOP, advancing once every 8 clocks, so one PWM period lasts 8×(TOP+1) clocks. Two consecutive strobes are exactly this far apart.
- R4: One tone cycle is 32 PWM periods, which is 256×(TOP+1) clocks. The sample index wraps from 31 back to 0.
- R5: Sample k equals round(TOP/2 × (1 + sin(2πk/32))), with ties rounded up. Sample 8 equals TOP and sample 24 equals 0.
- R6: pwm_o is low while the counter is below the compare value and high from the match through TOP. A period with compare value s therefore holds pwm_o high for 8×(TOP+1−s) clocks.
- R7: The compare value is loaded at the counter wrap, in the same clock as the strobe. The n-th strobe after reset (n ≥ 1) starts a period that uses sample (n−1) mod 32.
- R8: sample_stb_o is a single-clock pulse at each sample update, and it occurs only while stepping is enabled.
- R9: A falling edge on key_ni raises tx_on_o on the third clock edge after the change, and stepping is then enabled. A rising edge lowers tx_on_o with the same latency and stops stepping.
- R10: While stepping is stopped, no strobes occur and pwm_o keeps the last duty cycle. When stepping resumes, the index continues from where it stopped.
- R11: Changes on tone_sel_i after the capture clock have no effect on the period or the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, nominally 12 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tone_sel_i | input | 3 | Tone select, captured after reset |
| key_ni | input | 1 | Active-low transmit key, asynchronous |
| pwm_o | output | 1 | PWM waveform carrying the tone |
| sample_stb_o | output | 1 | One-clock pulse at each sample update |
| tx_on_o | output | 1 | High while the key is active |

## Verification
An error in the prescaler or in the terminal count shows up as a wrong strobe spacing within the first PWM period. A wrong compare value or a wrong sample index appears in the high time of the period that follows its strobe, so each fault can be traced to one sample index within one period. A wrong wrap of the index, or a wrong freeze behaviour, only appears after a full tone cycle or across a key release. For this reason one tone is swept through 33 periods, and the key is released and pressed again in mid-cycle.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  localparam int TPG_CNT_W = 10;
  localparam int TPG_SEL_W = 3;
  localparam int TPG_IDX_W = 5;   // 32 samples per tone cycle
  localparam int TPG_FRAC  = 16;  // fraction bits of the sine magnitude

  // Period terminal count for each tone select code (R2)
  function automatic logic [TPG_CNT_W-1:0] tone_top(input logic [TPG_SEL_W-1:0] s);
    logic [TPG_CNT_W-1:0] t;
    case (s)
      3'd0:    t = 10'd289;
      3'd1:    t = 10'd699;
      3'd2:    t = 10'd529;
      3'd3:    t = 10'd552;
      3'd4:    t = 10'd468;
      3'd5:    t = 10'd452;
      3'd6:    t = 10'd608;
      default: t = 10'd548;
    endcase
    return t;
  endfunction

  // sin(m*pi/16) for m = 0..8, in unsigned Q1.16
  function automatic logic [TPG_FRAC:0] quarter_sin(input logic [3:0] m);
    logic [TPG_FRAC:0] v;
    case (m)
      4'd0:    v = 17'd0;
      4'd1:    v = 17'd12785;
      4'd2:    v = 17'd25080;
      4'd3:    v = 17'd36410;
      4'd4:    v = 17'd46341;
      4'd5:    v = 17'd54491;
      4'd6:    v = 17'd60547;
      4'd7:    v = 17'd64277;
      default: v = 17'd65536;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tpg_key_sync.sv
module tpg_key_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_ni,
  output logic tx_on_o
);

  logic [1:0] sync_q, sync_d;
  logic       prev_q, prev_d;
  logic       tx_q, tx_d;
  logic       key_fall, key_rise;

  assign key_fall = prev_q & ~sync_q[1];
  assign key_rise = ~prev_q & sync_q[1];

  always_comb begin
    sync_d = {sync_q[0], key_ni};
    prev_d = sync_q[1];
    tx_d   = tx_q;
    if (key_fall)      tx_d = 1'b1;
    else if (key_rise) tx_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
      tx_q   <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      tx_q   <= tx_d;
    end
  end

  assign tx_on_o = tx_q;

  AST_TX_ON_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(key_fall) |-> tx_q); // R9
  AST_TX_OFF_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(key_rise) |-> !tx_q); // R9

endmodule

// File: rtl/tpg_sample_calc.sv
module tpg_sample_calc
  import tpg_pkg::*;
#(
  parameter int CNT_W = TPG_CNT_W,
  parameter int IDX_W = TPG_IDX_W
) (
  input  logic [CNT_W-1:0] top_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] samp_o
);

  localparam int POS_W = IDX_W - 2;
  localparam int ONE   = 1 << TPG_FRAC;
  localparam int FAC_W = TPG_FRAC + 2;
  localparam int PRD_W = CNT_W + FAC_W;

  logic [1:0]        quad;
  logic [POS_W-1:0]  pos;
  logic [3:0]        mag_idx;
  logic [TPG_FRAC:0] mag;
  logic [FAC_W-1:0]  factor;
  logic [PRD_W-1:0]  prod;

  assign quad = idx_i[IDX_W-1 -: 2];
  assign pos  = idx_i[POS_W-1:0];

  always_comb begin
    // mirror the magnitude in the second and fourth quarters
    if (quad[0]) mag_idx = 4'd8 - 4'(pos);
    else         mag_idx = 4'(pos);
    mag = quarter_sin(mag_idx);
    // negative half in the lower two quarters
    if (quad[1]) factor = FAC_W'(ONE) - FAC_W'(mag);
    else         factor = FAC_W'(ONE) + FAC_W'(mag);
    // TOP/2 * (1 + sin), rounded half up
    prod   = PRD_W'(top_i) * PRD_W'(factor) + PRD_W'(ONE);
    samp_o = CNT_W'(prod >> (TPG_FRAC + 1));
  end

endmodule

// File: rtl/tpg_pwm_core.sv
module tpg_pwm_core
  import tpg_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int CNT_W    = TPG_CNT_W,
  parameter int IDX_W    = TPG_IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic [CNT_W-1:0] samp_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             pwm_o,
  output logic             stb_o
);

  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]  ps_q, ps_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             stb_q, stb_d;
  logic             tick, wrap, load;

  assign tick = run_i & (ps_q == PS_LAST);
  assign wrap = tick & (cnt_q == top_i);
  assign load = wrap & step_i;

  always_comb begin
    ps_d  = ps_q;
    cnt_d = cnt_q;
    cmp_d = cmp_q;
    idx_d = idx_q;
    stb_d = load;
    if (run_i) begin
      if (tick) ps_d = '0;
      else      ps_d = ps_q + 1'b1;
    end
    if (wrap)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
    if (load) begin
      cmp_d = samp_i;
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q  <= '0;
      cnt_q <= '0;
      cmp_q <= '0;
      idx_q <= '0;
      stb_q <= 1'b0;
    end else begin
      ps_q  <= ps_d;
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      idx_q <= idx_d;
      stb_q <= stb_d;
    end
  end

  assign idx_o = idx_q;
  assign stb_o = stb_q;
  assign pwm_o = (cnt_q >= cmp_q);

  AST_CNT_WITHIN_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= top_i); // R3
  AST_CMP_WITHIN_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q <= top_i); // R5
  AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q); // R8
  AST_STB_NEEDS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> $past(step_i)); // R8
  AST_STB_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (cnt_q == '0)); // R7
  AST_IDX_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (idx_q == $past(idx_q) + 1'b1)); // R4
  AST_CMP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_i) |-> ($stable(cmp_q) && $stable(idx_q))); // R10

endmodule

// File: rtl/tone_pwm_gen.sv
module tone_pwm_gen
  import tpg_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int CNT_W    = TPG_CNT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TPG_SEL_W-1:0] tone_sel_i,
  input  logic                 key_ni,
  output logic                 pwm_o,
  output logic                 sample_stb_o,
  output logic                 tx_on_o
);

  localparam int IDX_W = TPG_IDX_W;

  logic [TPG_SEL_W-1:0] sel_q, sel_d;
  logic                 init_q, init_d;
  logic [CNT_W-1:0]     top_w;
  logic [CNT_W-1:0]     samp_w;
  logic [IDX_W-1:0]     idx_w;
  logic                 tx_w;

  // one-shot capture of the tone select
  always_comb begin
    sel_d  = sel_q;
    init_d = 1'b1;
    if (!init_q) sel_d = tone_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      init_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      init_q <= init_d;
    end
  end

  assign top_w = CNT_W'(tone_top(sel_q));

  tpg_key_sync i_key (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_ni  (key_ni),
    .tx_on_o (tx_w)
  );

  tpg_sample_calc #(
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) i_calc (
    .top_i  (top_w),
    .idx_i  (idx_w),
    .samp_o (samp_w)
  );

  tpg_pwm_core #(
    .PRESCALE (PRESCALE),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (init_q),
    .step_i (tx_w),
    .top_i  (top_w),
    .samp_i (samp_w),
    .idx_o  (idx_w),
    .pwm_o  (pwm_o),
    .stb_o  (sample_stb_o)
  );

  assign tx_on_o = tx_w;

  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && $past(init_q)) |-> $stable(sel_q)); // R11
  AST_NO_STB_BEFORE_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |-> !sample_stb_o); // R1

endmodule

// File: tb/test_tone_pwm_gen.sv
`timescale 1ns/1ps
module test_tone_pwm_gen;

  logic       clk;
  logic       rst_n;
  logic [2:0] sel;
  logic       key_n;
  logic       pwm;
  logic       stb;
  logic       tx_on;

  int checks   = 0;
  int failures = 0;

  localparam int NVEC = 8;
  // stimulus: select code i, expected TOP (R2)
  localparam int VEC_TOP [NVEC] = '{289, 699, 529, 552, 468, 452, 608, 548};

  tone_pwm_gen i_tone_pwm_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tone_sel_i   (sel),
    .key_ni       (key_n),
    .pwm_o        (pwm),
    .sample_stb_o (stb),
    .tx_on_o      (tx_on)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic real samp_real(input int top, input int k);
    return (top / 2.0) * (1.0 + $sin(2.0 * 3.14159265358979 * k / 32.0));
  endfunction

  function automatic int samp_exp(input int top, input int k);
    return $rtoi($floor(samp_real(top, k) + 0.5));
  endfunction

  // true if the high time matches the sample, allowing either neighbour on a near-tie
  function automatic bit hi_ok(input int top, input int k, input int hi);
    real v;
    real fr;
    int  s;
    v  = samp_real(top, k);
    fr = v - $floor(v);
    s  = samp_exp(top, k);
    if (hi == 8 * (top + 1 - s)) return 1'b1;
    if ((fr > 0.49) && (fr < 0.51) && (hi == 8 * (top + 2 - s))) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int code);
    rst_n = 1'b0;
    key_n = 1'b1;
    sel   = 3'(code);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_stb();
    @(negedge clk);
    while (!stb) @(negedge clk);
  endtask

  // from a strobe cycle, measure the period up to the next strobe
  task automatic next_window(output int len, output int hi);
    len = 0;
    hi  = 0;
    do begin
      len++;
      if (pwm) hi++;
      @(negedge clk);
    end while (!stb);
  endtask

  initial begin
    int len;
    int hi;
    int total;
    int top;
    int cnt_stb;

    rst_n = 1'b0;
    key_n = 1'b1;
    sel   = 3'd0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(tx_on == 1'b0, "R1 tx_on in reset", int'(tx_on), 0);
    check(stb == 1'b0, "R1 strobe in reset", int'(stb), 0);
    check(pwm == 1'b1, "R1 pwm in reset", int'(pwm), 1);

    // vector loop over all tone codes
    for (int v = 0; v < NVEC; v++) begin
      top = VEC_TOP[v];
      do_reset(v);
      key_n = 1'b0;
      repeat (4) @(negedge clk);
      check(tx_on == 1'b1, "R9 tx_on after key low", int'(tx_on), 1);
      wait_stb();
      total = 0;
      for (int k = 0; k < ((v == 0) ? 33 : 1); k++) begin
        next_window(len, hi);
        if (k < 32) total += len;
        // R2 R3: period length from the selected TOP
        check(len == 8 * (top + 1), "R3 period length", len, 8 * (top + 1));
        // R5 R6 R7: high time from sample (k mod 32)
        check(hi_ok(top, k % 32, hi), "R6 high time", hi, 8 * (top + 1 - samp_exp(top, k % 32)));
        if (v == 0 && k == 8)
          check(hi == 8, "R5 sample 8 equals TOP", hi, 8);
        if (v == 0 && k == 24)
          check(hi == 8 * (top + 1), "R5 sample 24 equals 0", hi, 8 * (top + 1));
        if (v == 0 && k == 32)
          check(hi_ok(top, 0, hi), "R4 index wrap to 0", hi, 8 * (top + 1 - samp_exp(top, 0)));
      end
      if (v == 0)
        check(total == 256 * (top + 1), "R4 tone cycle length", total, 256 * (top + 1));
    end

    // directed: key release freezes duty, select change ignored, resume
    top = 289;
    do_reset(0);
    key_n = 1'b0;
    wait_stb();
    next_window(len, hi);
    next_window(len, hi);
    // now at strobe 3: compare holds sample 2
    key_n = 1'b1;
    sel   = 3'd1;
    repeat (4) @(negedge clk);
    check(tx_on == 1'b0, "R9 tx_on after key high", int'(tx_on), 0);
    cnt_stb = 0;
    for (int w = 0; w < 2; w++) begin
      hi = 0;
      for (int c = 0; c < 8 * (top + 1); c++) begin
        if (pwm) hi++;
        if (stb) cnt_stb++;
        @(negedge clk);
      end
      check(hi_ok(top, 2, hi), "R10 frozen duty", hi, 8 * (top + 1 - samp_exp(top, 2)));
    end
    check(cnt_stb == 0, "R8 no strobe while stopped", cnt_stb, 0);
    key_n = 1'b0;
    wait_stb();
    next_window(len, hi);
    check(len == 8 * (top + 1), "R11 select change ignored", len, 8 * (top + 1));
    check(hi_ok(top, 3, hi), "R10 resume at next index", hi, 8 * (top + 1 - samp_exp(top, 3)));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule